// File: doc/BRIEF.md
# Display Status and Software SPI Port

This block sits on a CPU I/O bus as one 16-bit port with two jobs. A read returns a status word. Its low byte carries display blanking flags and the level of a serial receive pin, and its high byte carries the last byte collected from an SD card. A write drives a serial link to the card, one bit per access, so the software produces every clock edge itself. A byte write sends one data bit, collects one bit and gives one clock pulse. A word write only moves the card select.

Every access that the bus completes, read or write, also raises a one-cycle pulse on a side output. A neighbouring display block uses that pulse to return its attribute port to the index phase.

The serial clock is generated by a small state machine with three states:
- `SCK_IDLE` (clock low) moves to `SCK_HIGH` on a byte write.
- `SCK_HIGH` (clock high) holds while no bus enable arrives. On the next enabled cycle it moves to `SCK_IDLE`, or to `SCK_GAP` if that cycle carries another byte write.
- `SCK_GAP` (clock low) moves to `SCK_HIGH` on the next enabled cycle.

Top module: `vstat_spi_port`

## Requirements
- R1: Read bit 0 equals hblank OR vblank, taken combinationally from the current inputs.
- R2: Read bit 1 shows the receive pin as sampled by one register, so it lags the pin by one clock.
- R3: Read bit 3 equals vblank, read bit 7 is always 1, and read bits 2, 4, 5 and 6 are always 0.
- R4: A byte write (select, enable, write, word flag low) loads data bit 7 onto MOSI at that clock edge. MOSI holds until the next byte write.
- R5: A byte write made while SCK is low and no pulse is pending raises SCK at that edge. SCK stays high until the next enabled cycle and falls at that edge, so it is high for exactly one enabled cycle.
- R6: A byte write that arrives in the enabled cycle that ends a high SCK sends SCK low for one enabled cycle and then high for one more. A byte write that lands in that low gap updates the data but shares the pending pulse.
- R7: Each byte write shifts the MISO level into bit 0 of the receive byte and moves the older bits toward bit 7. The receive byte is shown on read bits 15:8.
- R8: A word write drives the active-low card select from data bit 8: a 1 asserts it (low) and a 0 releases it (high).
- R9: Reads, word writes and any cycle with the bus enable low leave MOSI, SCK progress and the receive byte unchanged. Byte writes leave the card select unchanged.
- R10: The attribute-reset output is high for exactly the one clock that follows each enabled access to the port (read or write), and low otherwise.
- R11: Synchronous reset gives SCK low, MOSI low, a receive byte of 0, card select released (high), a receive-pin sample of 0 and the attribute-reset output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_ce | input | 1 | CPU clock enable; a bus cycle completes only when high |
| port_sel | input | 1 | Address decode hit for this port |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| wdata | input | 16 | Write data from the CPU |
| rdata | output | 16 | Status word for reads |
| hblank | input | 1 | Horizontal blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| rx_pin | input | 1 | Serial receive line |
| spi_miso | input | 1 | Data from the card |
| spi_mosi | output | 1 | Data to the card |
| spi_sck | output | 1 | Serial clock to the card |
| spi_cs_n | output | 1 | Card select, active low |
| attr_idx_clr | output | 1 | One-cycle pulse after each port access |

## Verification
Byte writes are applied in four ways: widely spaced with the enable always high, with the enable high one cycle in three, back to back on consecutive enabled cycles, and mixed at random with reads and word writes. The first two patterns separate a pulse length counted in enabled cycles from one counted in clocks. The back-to-back pattern exercises the gap path. The random mix shows whether word writes, reads or cycles without the enable disturb MOSI, SCK or the receive byte. The blanking, receive and MISO inputs change at random every cycle, so a stuck or crossed status bit or a shift in the wrong direction shows up against the behavioural model.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
    // Serial clock generator states
    typedef enum logic [1:0] {
        SCK_IDLE = 2'd0,
        SCK_HIGH = 2'd1,
        SCK_GAP  = 2'd2
    } sck_state_e;

    localparam int STATUS_W = 8;
endpackage

// File: rtl/vsp_bus_decode.sv
module vsp_bus_decode (
    input  logic clk,
    input  logic rst,
    input  logic bus_ce,
    input  logic port_sel,
    input  logic bus_wr,
    input  logic bus_word,
    output logic byte_wr,
    output logic word_wr,
    output logic attr_idx_clr
);
    logic access;
    logic clr_q;

    assign access  = port_sel & bus_ce;
    assign byte_wr = access & bus_wr & ~bus_word;
    assign word_wr = access & bus_wr & bus_word;

    always_ff @(posedge clk) begin
        if (rst) clr_q <= 1'b0;
        else     clr_q <= access;
    end

    assign attr_idx_clr = clr_q;

    p_attr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (port_sel && bus_ce) |=> attr_idx_clr);
    p_attr_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(port_sel && bus_ce) |=> !attr_idx_clr);
endmodule

// File: rtl/vsp_sck_fsm.sv
module vsp_sck_fsm
    import vsp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_ce,
    input  logic byte_wr,
    output logic sck
);
    sck_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SCK_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCK_IDLE: if (byte_wr) state_d = SCK_HIGH;
            SCK_HIGH: if (bus_ce)  state_d = byte_wr ? SCK_GAP : SCK_IDLE;
            SCK_GAP:  if (bus_ce)  state_d = SCK_HIGH;
            default:               state_d = SCK_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SCK_HIGH: sck = 1'b1;
            default:  sck = 1'b0;
        endcase
    end

    p_sck_falls_r5: assert property (@(posedge clk) disable iff (rst)
        (sck && bus_ce) |=> !sck);
    p_sck_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (sck && !bus_ce) |=> sck);
    p_sck_rises_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SCK_IDLE && byte_wr) |=> sck);
    p_sck_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (sck && byte_wr) |=> (!sck && state_q == SCK_GAP));
    p_gap_resume_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SCK_GAP && bus_ce) |=> sck);
endmodule

// File: rtl/vsp_spi_data.sv
module vsp_spi_data #(
    parameter int RX_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_wr,
    input  logic            word_wr,
    input  logic            mosi_bit,
    input  logic            csel_bit,
    input  logic            spi_miso,
    output logic            spi_mosi,
    output logic            spi_cs_n,
    output logic [RX_W-1:0] rx_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            spi_mosi <= 1'b0;
            rx_byte  <= '0;
        end else if (byte_wr) begin
            spi_mosi <= mosi_bit;
            rx_byte  <= {rx_byte[RX_W-2:0], spi_miso};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          spi_cs_n <= 1'b1;
        else if (word_wr) spi_cs_n <= ~csel_bit;
    end

    p_mosi_load_r4: assert property (@(posedge clk) disable iff (rst)
        byte_wr |=> (spi_mosi == $past(mosi_bit)));
    p_shift_in_r7: assert property (@(posedge clk) disable iff (rst)
        byte_wr |=> (rx_byte == {$past(rx_byte[RX_W-2:0]), $past(spi_miso)}));
    p_csel_r8: assert property (@(posedge clk) disable iff (rst)
        word_wr |=> (spi_cs_n == !$past(csel_bit)));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !byte_wr |=> ($stable(rx_byte) && $stable(spi_mosi)));
endmodule

// File: rtl/vsp_status.sv
module vsp_status
    import vsp_pkg::*;
#(
    parameter int RX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hblank,
    input  logic                     vblank,
    input  logic                     rx_pin,
    input  logic [RX_W-1:0]          rx_byte,
    output logic [RX_W+STATUS_W-1:0] rdata
);
    logic            rx_q;
    logic [STATUS_W-1:0] stat;

    always_ff @(posedge clk) begin
        if (rst) rx_q <= 1'b0;
        else     rx_q <= rx_pin;
    end

    always_comb begin
        stat    = '0;
        stat[0] = hblank | vblank;
        stat[1] = rx_q;
        stat[3] = vblank;
        stat[7] = 1'b1;
    end

    assign rdata = {rx_byte, stat};

    p_rx_lag_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rdata[1] == $past(rx_pin)));
    p_fixed_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (rdata[7] && !rdata[2] && !rdata[4] && !rdata[5] && !rdata[6]));
endmodule

// File: rtl/vstat_spi_port.sv
module vstat_spi_port #(
    parameter int DATA_W   = 16,
    parameter int MOSI_BIT = 7,
    parameter int CSEL_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce,
    input  logic              port_sel,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              rx_pin,
    input  logic              spi_miso,
    output logic              spi_mosi,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              attr_idx_clr
);
    localparam int RX_W = DATA_W - vsp_pkg::STATUS_W;

    logic byte_wr;
    logic word_wr;
    logic [RX_W-1:0] rx_byte;
    logic wdata_unused;

    assign wdata_unused = ^wdata;

    vsp_bus_decode u_dec (
        .clk          (clk),
        .rst          (rst),
        .bus_ce       (bus_ce),
        .port_sel     (port_sel),
        .bus_wr       (bus_wr),
        .bus_word     (bus_word),
        .byte_wr      (byte_wr),
        .word_wr      (word_wr),
        .attr_idx_clr (attr_idx_clr)
    );

    vsp_sck_fsm u_sck (
        .clk     (clk),
        .rst     (rst),
        .bus_ce  (bus_ce),
        .byte_wr (byte_wr),
        .sck     (spi_sck)
    );

    vsp_spi_data #(.RX_W(RX_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .byte_wr  (byte_wr),
        .word_wr  (word_wr),
        .mosi_bit (wdata[MOSI_BIT]),
        .csel_bit (wdata[CSEL_BIT]),
        .spi_miso (spi_miso),
        .spi_mosi (spi_mosi),
        .spi_cs_n (spi_cs_n),
        .rx_byte  (rx_byte)
    );

    vsp_status #(.RX_W(RX_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .hblank  (hblank),
        .vblank  (vblank),
        .rx_pin  (rx_pin),
        .rx_byte (rx_byte),
        .rdata   (rdata)
    );

    p_csel_byte_r9: assert property (@(posedge clk) disable iff (rst)
        byte_wr |=> $stable(spi_cs_n));
endmodule

// File: tb/tb_vstat_spi_port.sv
module tb_vstat_spi_port;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        bus_ce = 1'b0, port_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        hblank = 1'b0, vblank = 1'b0, rx_pin = 1'b0, spi_miso = 1'b0;
    logic        spi_mosi, spi_sck, spi_cs_n, attr_idx_clr;

    vstat_spi_port dut (
        .clk(clk), .rst(rst), .bus_ce(bus_ce), .port_sel(port_sel),
        .bus_wr(bus_wr), .bus_word(bus_word), .wdata(wdata), .rdata(rdata),
        .hblank(hblank), .vblank(vblank), .rx_pin(rx_pin), .spi_miso(spi_miso),
        .spi_mosi(spi_mosi), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .attr_idx_clr(attr_idx_clr)
    );

    // Behavioural reference state
    logic       m_sck = 0, m_pend = 0, m_mosi = 0, m_csn = 1, m_attr = 0, m_rx = 0;
    logic [7:0] m_shift = 0;
    bit         started = 0;
    bit         done = 0;
    int         vectors = 0;
    int         fails = 0;
    string      phase = "R11 reset";

    always @(posedge clk) begin
        logic bw;
        started = 1;
        bw = port_sel & bus_ce & bus_wr & ~bus_word;
        if (rst) begin
            m_sck = 0; m_pend = 0; m_mosi = 0; m_csn = 1; m_attr = 0; m_rx = 0; m_shift = 0;
        end else begin
            m_rx   = rx_pin;
            m_attr = port_sel & bus_ce;
            if (port_sel & bus_ce & bus_wr & bus_word) m_csn = ~wdata[8];
            if (bw) begin
                m_mosi  = wdata[7];
                m_shift = {m_shift[6:0], spi_miso};
            end
            if (bus_ce) begin
                if (m_sck) begin
                    m_sck = 0;
                    if (bw) m_pend = 1;
                end else if (m_pend) begin
                    m_sck = 1; m_pend = 0;
                end else if (bw) begin
                    m_sck = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (phase %s) t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            chk("R1 bit0",  {15'd0, rdata[0]}, {15'd0, hblank | vblank});
            chk("R2 bit1",  {15'd0, rdata[1]}, {15'd0, m_rx});
            chk("R3 bits7:2", {10'd0, rdata[7:2]}, {10'd0, 1'b1, 3'b000, vblank, 1'b0});
            chk("R7 rxbyte", {8'd0, rdata[15:8]}, {8'd0, m_shift});
            chk("R4 mosi",  {15'd0, spi_mosi}, {15'd0, m_mosi});
            chk("R5 R6 sck", {15'd0, spi_sck}, {15'd0, m_sck});
            chk("R8 csn",   {15'd0, spi_cs_n}, {15'd0, m_csn});
            chk("R10 attr", {15'd0, attr_idx_clr}, {15'd0, m_attr});
        end
    end

    task automatic cyc(input logic c_ce, input logic c_sel, input logic c_wr,
                       input logic c_word, input logic [15:0] d);
        @(posedge clk);
        #2;
        bus_ce = c_ce; port_sel = c_sel; bus_wr = c_wr; bus_word = c_word; wdata = d;
        hblank = 1'($urandom); vblank = 1'($urandom);
        rx_pin = 1'($urandom); spi_miso = 1'($urandom);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog (phase %s) actual=running expected=finished", phase);
        finish_run();
    end

    initial begin
        // R11: reset state
        rst = 1;
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 16'h0);
        rst = 0;

        phase = "R4 R5 R7 spaced byte writes";
        for (int i = 0; i < 24; i++) begin
            cyc(1, 1, 1, 0, 16'($urandom));
            for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 16'h0);
        end

        phase = "R5 R9 enable one in three";
        for (int i = 0; i < 300; i++)
            cyc(i % 3 == 0, 1, (i % 6 == 0) || (i % 3 == 1), 0, 16'($urandom));

        phase = "R6 back-to-back byte writes";
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 16'($urandom));
            for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 16'h0);
        end

        phase = "R8 word writes";
        cyc(1, 1, 1, 1, 16'h0100);
        cyc(1, 0, 0, 0, 16'h0);
        cyc(1, 1, 1, 1, 16'h00FF);
        cyc(1, 0, 0, 0, 16'h0);
        cyc(1, 1, 1, 1, 16'hFFFF);
        cyc(1, 1, 1, 0, 16'h0000);
        cyc(0, 1, 1, 1, 16'h0000);
        for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 16'h0);

        phase = "R9 R10 reads and disabled cycles";
        for (int i = 0; i < 200; i++)
            cyc(1'($urandom), 1, (i % 4) == 0, 1'($urandom), 16'($urandom));

        phase = "R1 R2 R3 status idle";
        for (int i = 0; i < 100; i++) cyc(1, 0, 0, 0, 16'h0);

        phase = "R9 mixed traffic";
        for (int i = 0; i < 4000; i++)
            cyc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));

        phase = "R11 reset again";
        rst = 1;
        cyc(1, 1, 1, 0, 16'hFFFF);
        cyc(1, 1, 1, 1, 16'hFFFF);
        rst = 0;
        for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, 16'h0);

        finish_run();
    end
endmodule